// File: doc/BRIEF.md
# Multichannel UART Sleep and Wake Controller

This block decides when a four-channel UART may stop its clock to save power, and when it must start it again. Each channel reports its status to the block: pending interrupt, transmit and receive FIFO empty flags, whether it runs in infrared mode, its baud divisor, the raw receive pin and the raw modem input pins. The host write strobe for each channel's transmit holding register also comes in, together with one global sleep-enable bit.

The block asleep drops a clock-enable output that gates the UART core clock. Sleep is entered only when sleep is enabled and every channel is idle at the same time. Any cause of activity on any channel, or a clear of the enable bit, restarts the clock. The block then keeps the clock running for a minimum number of cycles and returns to sleep by itself once all causes have gone, with no host action. Each wake raises a wake-up flag on every channel. The flag stays set, asleep or awake, until that channel acknowledges it.

The receive and modem pins are asynchronous. They pass through a two-flop synchronizer and an edge detector inside the block, which runs on a free-running reference clock.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: After reset the block is awake: `clk_en_o`=1, `asleep_o`=0, every `wake_irq_o` bit 0.
- R2: Sleep is entered only while `sleep_en_i`=1 and, on every channel, `irq_pend_i`=0, `tx_empty_i`=1, `rx_empty_i`=1 and `thr_wr_i`=0.
- R3: A channel's receive pin counts as idle when it is high with `ir_mode_i`=0, or low with `ir_mode_i`=1. Any other level blocks sleep.
- R4: A channel whose divisor field is zero, or whose modem field has any bit set, blocks sleep.
- R5: A single channel failing any condition of R2 to R4 keeps the whole block awake, whichever channel it is.
- R6: While asleep, `clk_en_o`=0 and `asleep_o`=1.
- R7: While asleep, a low `sleep_en_i`, a high `irq_pend_i` bit, or a `thr_wr_i` pulse wakes the block at the next clock edge.
- R8: While asleep, a change on a receive pin or a modem pin of any channel wakes the block at the third clock edge after the change.
- R9: On each wake all `wake_irq_o` bits are set. A bit clears one edge after its `wake_ack_i` bit is high. It stays set through sleep if not acknowledged.
- R10: After a wake the block stays awake for exactly `MIN_AWAKE` further edges. If still idle, it sleeps at the edge after that.
- R11: Once the wake cause clears, the block goes back to sleep with no host action. A pending wake-up flag does not prevent this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_en_i | input | 1 | Global sleep enable |
| irq_pend_i | input | NUM_CH | Per-channel interrupt pending |
| tx_empty_i | input | NUM_CH | Per-channel transmit FIFO empty |
| rx_empty_i | input | NUM_CH | Per-channel receive FIFO empty |
| ir_mode_i | input | NUM_CH | Per-channel infrared mode (inverts the idle receive level) |
| divisor_i | input | NUM_CH*DIV_W | Packed baud divisors, channel 0 in the low bits |
| rx_pin_i | input | NUM_CH | Raw asynchronous receive pins |
| modem_i | input | NUM_CH*MDM_W | Raw modem input pins, channel 0 in the low bits |
| thr_wr_i | input | NUM_CH | Transmit holding register write strobes |
| wake_ack_i | input | NUM_CH | Per-channel clear of the wake-up flag |
| clk_en_o | output | 1 | Clock-gate enable for the UART core |
| asleep_o | output | 1 | Block is in the sleep state |
| wake_irq_o | output | NUM_CH | Per-channel wake-up indicator interrupt |

## Verification
The bench sweeps every blocking condition over every channel. A design that ANDed the conditions over only some channels, or mixed up the infrared idle level, would sleep while that channel was busy. It measures wake latency to the exact edge for direct causes and for synchronized pin changes. A missing or extra synchronizer stage would shift the wake by one edge. It also counts the awake window edge by edge after a wake: an off-by-one counter would sleep one edge early or late. Wake flags are checked to survive sleep until they are acknowledged, and to be set again on the next wake.

// File: rtl/uart_slp_pkg.sv
package uart_slp_pkg;
   typedef enum logic {
      ST_AWAKE = 1'b0,
      ST_SLEEP = 1'b1
   } slp_state_e;
endpackage

// File: rtl/slp_sync2.sv
module slp_sync2 #(
   parameter int          WIDTH   = 1,
   parameter logic [63:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("slp_sync2: WIDTH must be 1..64");
   end

   logic [WIDTH-1:0] meta_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         meta_q <= RST_VAL[WIDTH-1:0];
         q_o    <= RST_VAL[WIDTH-1:0];
      end else begin
         meta_q <= d_i;
         q_o    <= meta_q;
      end
   end
endmodule

// File: rtl/slp_chan_idle.sv
module slp_chan_idle #(
   parameter int DIV_W = 16,
   parameter int MDM_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             irq_pend_i,
   input  logic             tx_empty_i,
   input  logic             rx_empty_i,
   input  logic             ir_mode_i,
   input  logic [DIV_W-1:0] divisor_i,
   input  logic             rx_pin_i,
   input  logic [MDM_W-1:0] modem_i,
   input  logic             thr_wr_i,
   output logic             idle_o
);
   logic             rx_s, rx_q;
   logic [MDM_W-1:0] mdm_s, mdm_q;
   logic             pin_activity;
   logic             rx_at_rest;
   logic             status_quiet;

   slp_sync2 #(.WIDTH(1), .RST_VAL(64'd1)) u_rx_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (rx_pin_i),
      .q_o   (rx_s)
   );

   slp_sync2 #(.WIDTH(MDM_W), .RST_VAL(64'd0)) u_mdm_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (modem_i),
      .q_o   (mdm_s)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_q  <= 1'b1;
         mdm_q <= '0;
      end else begin
         rx_q  <= rx_s;
         mdm_q <= mdm_s;
      end
   end

   always_comb begin
      pin_activity = (rx_s ^ rx_q) | (|(mdm_s ^ mdm_q));
      rx_at_rest   = ir_mode_i ? ~rx_s : rx_s;
      status_quiet = ~irq_pend_i & tx_empty_i & rx_empty_i & ~thr_wr_i;
      idle_o       = status_quiet & rx_at_rest & (divisor_i != '0)
                   & (mdm_s == '0) & ~pin_activity;
   end

   // R4: a channel with settled nonzero modem pins never reports idle
   a_r4_modem_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mdm_q != '0) && $stable(mdm_q) |-> !idle_o);
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
   import uart_slp_pkg::*;
#(
   parameter int MIN_AWAKE = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sleep_en_i,
   input  logic all_idle_i,
   output logic asleep_o,
   output logic wake_o
);
   localparam int CNT_W = $clog2(MIN_AWAKE + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_AWAKE);

   if (MIN_AWAKE < 1) begin : g_bad_min
      $error("slp_fsm: MIN_AWAKE must be at least 1");
   end

   slp_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             may_sleep;
   logic             hold_done;

   always_comb begin
      may_sleep = sleep_en_i & all_idle_i;
      hold_done = (cnt_q == CNT_MAX);
      wake_o    = (state_q == ST_SLEEP) & ~may_sleep;
      asleep_o  = (state_q == ST_SLEEP);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_AWAKE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_AWAKE: begin
               if (!hold_done) cnt_q <= cnt_q + CNT_W'(1);
               if (hold_done && may_sleep) state_q <= ST_SLEEP;
            end
            default: begin
               cnt_q <= '0;
               if (!may_sleep) state_q <= ST_AWAKE;
            end
         endcase
      end
   end

   // R10: sleep is only entered once the awake window has run out
   a_r10_min_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_SLEEP) && ($past(state_q) == ST_AWAKE) |-> $past(cnt_q) == CNT_MAX);

   // R2: entering sleep requires the enable bit in the cycle before
   a_r2_entry_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(asleep_o) |-> $past(sleep_en_i));
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl #(
   parameter int NUM_CH    = 4,
   parameter int DIV_W     = 16,
   parameter int MDM_W     = 4,
   parameter int MIN_AWAKE = 8
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    sleep_en_i,
   input  logic [NUM_CH-1:0]       irq_pend_i,
   input  logic [NUM_CH-1:0]       tx_empty_i,
   input  logic [NUM_CH-1:0]       rx_empty_i,
   input  logic [NUM_CH-1:0]       ir_mode_i,
   input  logic [NUM_CH*DIV_W-1:0] divisor_i,
   input  logic [NUM_CH-1:0]       rx_pin_i,
   input  logic [NUM_CH*MDM_W-1:0] modem_i,
   input  logic [NUM_CH-1:0]       thr_wr_i,
   input  logic [NUM_CH-1:0]       wake_ack_i,
   output logic                    clk_en_o,
   output logic                    asleep_o,
   output logic [NUM_CH-1:0]       wake_irq_o
);
   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
      $error("uart_sleep_ctrl: NUM_CH must be 1..32");
   end
   if (DIV_W < 1 || MDM_W < 1) begin : g_bad_w
      $error("uart_sleep_ctrl: field widths must be positive");
   end

   logic [NUM_CH-1:0] ch_idle;
   logic              all_idle;
   logic              wake;
   logic              asleep;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      slp_chan_idle #(.DIV_W(DIV_W), .MDM_W(MDM_W)) u_idle (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .irq_pend_i(irq_pend_i[c]),
         .tx_empty_i(tx_empty_i[c]),
         .rx_empty_i(rx_empty_i[c]),
         .ir_mode_i (ir_mode_i[c]),
         .divisor_i (divisor_i[c*DIV_W +: DIV_W]),
         .rx_pin_i  (rx_pin_i[c]),
         .modem_i   (modem_i[c*MDM_W +: MDM_W]),
         .thr_wr_i  (thr_wr_i[c]),
         .idle_o    (ch_idle[c])
      );

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)           wake_irq_o[c] <= 1'b0;
         else if (wake)         wake_irq_o[c] <= 1'b1;
         else if (wake_ack_i[c]) wake_irq_o[c] <= 1'b0;
      end
   end

   assign all_idle = &ch_idle;

   slp_fsm #(.MIN_AWAKE(MIN_AWAKE)) u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sleep_en_i(sleep_en_i),
      .all_idle_i(all_idle),
      .asleep_o  (asleep),
      .wake_o    (wake)
   );

   assign asleep_o = asleep;
   assign clk_en_o = ~asleep;

   // R7: clearing the enable while asleep wakes at the next edge
   a_r7_disable_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      asleep_o && !sleep_en_i |=> !asleep_o);

   // R7: a transmit holding register write while asleep wakes at the next edge
   a_r7_thr_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      asleep_o && (|thr_wr_i) |=> !asleep_o);

   // R9: every channel's wake-up flag is set when the block leaves sleep
   a_r9_wake_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(asleep_o) |-> (&wake_irq_o));

   // R5: a busy channel FIFO keeps the block awake
   a_r5_fifo_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !asleep_o && !(&tx_empty_i) |=> !asleep_o);
endmodule

// File: tb/tb_uart_sleep_ctrl.sv
module tb_uart_sleep_ctrl;
   localparam int NCH = 4;
   localparam int DW  = 16;
   localparam int MW  = 4;
   localparam int MIN = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic           sleep_en;
   logic [NCH-1:0] irq, txe, rxe, ir, rx, thr, ack;
   logic [NCH*DW-1:0] div;
   logic [NCH*MW-1:0] mdm;
   logic           clk_en, asleep;
   logic [NCH-1:0] wirq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   uart_sleep_ctrl #(.NUM_CH(NCH), .DIV_W(DW), .MDM_W(MW), .MIN_AWAKE(MIN)) dut (
      .clk_i(clk), .rst_ni(rst_n), .sleep_en_i(sleep_en),
      .irq_pend_i(irq), .tx_empty_i(txe), .rx_empty_i(rxe), .ir_mode_i(ir),
      .divisor_i(div), .rx_pin_i(rx), .modem_i(mdm), .thr_wr_i(thr),
      .wake_ack_i(ack), .clk_en_o(clk_en), .asleep_o(asleep), .wake_irq_o(wirq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic all_idle();
      sleep_en = 1'b1; irq = '0; txe = '1; rxe = '1; ir = '0; rx = '1;
      thr = '0; ack = '0; mdm = '0;
      for (int c = 0; c < NCH; c++) div[c*DW +: DW] = DW'(c + 1);
   endtask

   task automatic wait_sleep(input int limit, output int waited);
      waited = 0;
      while (!asleep && waited < limit) begin
         @(negedge clk);
         waited++;
      end
   endtask

   task automatic make_bad(input int c, input int k);
      case (k)
         0: irq[c] = 1'b1;
         1: txe[c] = 1'b0;
         2: rxe[c] = 1'b0;
         3: rx[c] = 1'b0;
         4: div[c*DW +: DW] = '0;
         5: mdm[c*MW +: MW] = MW'(1 << (c % MW));
         default: ir[c] = 1'b1;
      endcase
   endtask

   initial begin
      int w;
      bit stayed;
      all_idle();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(clk_en == 1'b1 && asleep == 1'b0 && wirq == '0, "R1 reset", {wirq, asleep, clk_en}, 1);
      rst_n = 1'b1;

      // R6: reaches sleep with everything idle; gate off
      wait_sleep(40, w);
      chk(asleep == 1'b1 && clk_en == 1'b0, "R6 asleep gate off", {asleep, clk_en}, 2);
      chk(w == MIN + 1, "R10 first sleep after reset", w, MIN + 1);

      // R7/R9/R10: thr pulse wake, exact window
      @(negedge clk); thr[1] = 1'b1;
      @(negedge clk); thr[1] = 1'b0;
      chk(clk_en == 1'b1 && asleep == 1'b0, "R7 thr wake latency", clk_en, 1);
      chk(wirq == '1, "R9 wake flags set", wirq, 15);
      stayed = 1'b1;
      for (int i = 0; i < MIN; i++) begin
         @(negedge clk);
         if (asleep) stayed = 1'b0;
      end
      chk(stayed, "R10 stays awake MIN edges", stayed, 1);
      @(negedge clk);
      chk(asleep == 1'b1, "R10 sleeps at MIN+1", asleep, 1);
      chk(wirq == '1, "R9 flags survive sleep", wirq, 15);

      // R9: ack one channel
      ack[2] = 1'b1;
      @(negedge clk); ack[2] = 1'b0;
      chk(wirq == 4'b1011, "R9 ack clears one flag", wirq, 11);

      // R7: disable wakes next edge
      sleep_en = 1'b0;
      @(negedge clk);
      chk(asleep == 1'b0, "R7 disable wake", asleep, 0);
      chk(wirq == '1, "R9 flag set again on wake", wirq, 15);
      repeat (MIN + 6) @(negedge clk);
      chk(asleep == 1'b0, "R2 no sleep while disabled", asleep, 0);
      ack = '1; @(negedge clk); ack = '0;
      chk(wirq == '0, "R9 ack all", wirq, 0);
      sleep_en = 1'b1;
      wait_sleep(MIN + 4, w);
      chk(asleep == 1'b1, "R11 re-sleep after enable", asleep, 1);

      // R7: interrupt pending wake, then R11 automatic re-sleep
      irq[3] = 1'b1;
      @(negedge clk);
      chk(asleep == 1'b0, "R7 irq wake latency", asleep, 0);
      irq[3] = 1'b0;
      wait_sleep(MIN + 4, w);
      chk(asleep == 1'b1 && wirq == '1, "R11 auto re-sleep with flags pending", {asleep, wirq}, 31);

      // R8: modem pin change, exact synchronizer latency
      mdm[2*MW +: MW] = 4'b0100;
      repeat (2) @(negedge clk);
      chk(asleep == 1'b1, "R8 still asleep after two edges", asleep, 1);
      @(negedge clk);
      chk(asleep == 1'b0, "R8 modem wake on third edge", asleep, 0);
      mdm = '0;
      wait_sleep(MIN + 8, w);
      chk(asleep == 1'b1, "R8 re-sleep after modem clears", asleep, 1);

      // R8: short receive pin pulse
      rx[0] = 1'b0;
      @(negedge clk); rx[0] = 1'b1;
      @(negedge clk);
      chk(asleep == 1'b1, "R8 rx pulse not yet seen", asleep, 1);
      @(negedge clk);
      chk(asleep == 1'b0, "R8 rx pulse wakes on third edge", asleep, 0);
      wait_sleep(MIN + 8, w);
      chk(asleep == 1'b1, "R8 re-sleep after rx pulse", asleep, 1);

      // R2..R5: every blocking condition on every channel
      for (int c = 0; c < NCH; c++) begin
         for (int k = 0; k < 7; k++) begin
            make_bad(c, k);
            repeat (4) @(negedge clk);
            stayed = 1'b1;
            for (int i = 0; i < MIN + 6; i++) begin
               @(negedge clk);
               if (asleep) stayed = 1'b0;
            end
            chk(stayed, (k == 3 || k == 6) ? "R3 wrong rx level blocks" :
                        (k == 4 || k == 5) ? "R4 divisor/modem blocks" :
                        "R5 channel status blocks", c * 10 + k, 1);
            all_idle();
            wait_sleep(MIN + 10, w);
            chk(asleep == 1'b1, "R2 sleeps once idle again", c * 10 + k, 1);
         end
      end

      // R3: infrared mode idles low on all channels
      ir = '1; rx = '0;
      repeat (4) @(negedge clk);
      wait_sleep(MIN + 10, w);
      chk(asleep == 1'b1, "R3 IR idle-low sleeps", asleep, 1);
      rx[1] = 1'b1;
      repeat (3) @(negedge clk);
      chk(asleep == 1'b0, "R3 IR high rx wakes", asleep, 0);

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) chk(1'b0, "watchdog", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule